// File: doc/BRIEF.md
# Sequential 128-by-64 Integer Divider with Divide-Error Detection

This block divides a double-width dividend, given as high and low 64-bit halves, by a single-width divisor. One control bit selects unsigned or two's-complement signed operation. It returns a 64-bit quotient and a 64-bit remainder. When the result cannot be represented, it raises a divide-error flag in place of a result, as a processor integer unit does. The block handles three such cases: a zero divisor, a quotient too wide for 64 bits, and the signed most-negative-dividend-by-minus-one case.

The arithmetic runs over several cycles. A one-cycle `start` loads the operands. Signed operands are first turned into magnitudes. A normalise phase then shifts a copy of the divisor left until it exceeds the dividend, counting the shifts. A restoring phase follows and spends one cycle per counted shift, each cycle shifting the divisor back right and making one trial subtraction. As a result, a small quotient takes few cycles and a large one takes more. A final cycle fixes the signs, checks the quotient range and pulses `done`. Whatever uses the result must wait for `done` and then read `div_err`, `quot` and `rem`.

Top module: `seqdiv_top`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy`, `done`, `div_err`, `quot` and `rem` are all zero.
- R2: A start with a zero divisor, in either mode, sets `done` and `div_err` in the cycle after the start edge, without any division cycles.
- R3: With `signed_mode`=0 and a quotient below 2^64, `quot` is floor({dvd_hi,dvd_lo}/dvsr) and `rem` is the modulus. The values arrive with `done` 2n+2 cycles after the start edge, where n is the number of k in 0..127 with dvsr*2^k <= dividend.
- R4: With `signed_mode`=0, a quotient of 2^64 or more sets `div_err` with `done` at the same 2n+2 cycle.
- R5: With `signed_mode`=1 (operands in two's complement, `dvd_hi` bit 63 being the dividend sign), the quotient magnitude is |A|/|D| and is negative when the operand signs differ. The remainder has the dividend's sign and a magnitude below |D|. Timing follows R3, with n computed on the magnitudes.
- R6: With `signed_mode`=1, `dvsr` all ones, `dvd_hi`=0x8000000000000000 and `dvd_lo`=0, `done` and `div_err` are set in the cycle after the start edge.
- R7: With `signed_mode`=1, a quotient outside -2^63..2^63-1 sets `div_err` at the 2n+2 cycle.
- R8: While `div_err` is high, `quot` and `rem` hold the values they had before the failing operation.
- R9: A dividend magnitude below the divisor magnitude gives a zero quotient and the dividend as remainder, with `done` 2 cycles after the start edge.
- R10: `done` is high for one cycle per accepted operation. `busy` is high from the cycle after a start edge until `done`, and is low while `done` is high. A `start` seen while `busy` is high is ignored, and the operation in progress finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept operands when not busy |
| signed_mode | input | 1 | 1 = two's-complement signed, 0 = unsigned |
| dvd_hi | input | 64 | Upper half of the dividend |
| dvd_lo | input | 64 | Lower half of the dividend |
| dvsr | input | 64 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Divide error, valid with done |
| quot | output | 64 | Quotient, updated only on success |
| rem | output | 64 | Remainder, updated only on success |

## Verification
Each result has a fixed delay after the start edge. The early errors (zero divisor, and most-negative by minus one) are due one cycle later. Every other outcome is due 2n+2 cycles later, where the bench finds n by its own doubling loop on the operand magnitudes. The bench drives a start, then samples at every falling edge. At each sample it checks that `busy` is high before the due cycle, and that `done` is low before it and high exactly at it. At that cycle it compares `div_err`, `quot` and `rem` against values computed with wide integer division. After an error, the expected values are the last successful outputs.

// File: rtl/seqdiv_pkg.sv
package seqdiv_pkg;

  // Iteration controller states of the divider core.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NORM = 2'd1,
    ST_DIV  = 2'd2,
    ST_FIN  = 2'd3
  } div_state_e;

  // Default operand width used by the top level.
  localparam int unsigned DIV_W_DEFAULT = 64;

endpackage

// File: rtl/seqdiv_prep.sv
// Sign stage: turns operands into magnitudes and flags the early errors.
module seqdiv_prep #(
  parameter int unsigned W = 64
) (
  input  logic           signed_mode,
  input  logic [W-1:0]   dvd_hi,
  input  logic [W-1:0]   dvd_lo,
  input  logic [W-1:0]   dvsr,
  output logic [2*W-1:0] dvd_mag,
  output logic [W-1:0]   dvs_mag,
  output logic           neg_quo,
  output logic           neg_rem,
  output logic           dvs_zero,
  output logic           min_by_m1
);

  localparam logic [W-1:0] TOP_ONLY = {1'b1, {(W-1){1'b0}}};

  function automatic logic [2*W-1:0] mag_wide(input logic [2*W-1:0] v, input logic neg);
    mag_wide = neg ? (~v + {{(2*W-1){1'b0}}, 1'b1}) : v;
  endfunction

  function automatic logic [W-1:0] mag_narrow(input logic [W-1:0] v, input logic neg);
    mag_narrow = neg ? (~v + {{(W-1){1'b0}}, 1'b1}) : v;
  endfunction

  logic dvd_neg;
  logic dvs_neg;

  assign dvd_neg   = signed_mode & dvd_hi[W-1];
  assign dvs_neg   = signed_mode & dvsr[W-1];
  assign dvd_mag   = mag_wide({dvd_hi, dvd_lo}, dvd_neg);
  assign dvs_mag   = mag_narrow(dvsr, dvs_neg);
  assign neg_quo   = dvd_neg ^ dvs_neg;
  assign neg_rem   = dvd_neg;
  assign dvs_zero  = (dvsr == '0);
  assign min_by_m1 = signed_mode && (&dvsr) && (dvd_hi == TOP_ONLY) && (dvd_lo == '0);

endmodule

// File: rtl/seqdiv_core.sv
// Normalise-then-restoring iteration engine on magnitudes.
module seqdiv_core
  import seqdiv_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [2*W-1:0] dvd_mag,
  input  logic [W-1:0]   dvs_mag,
  output logic           busy,
  output logic           fin,
  output logic [2*W-1:0] quo_raw,
  output logic [W-1:0]   rem_raw
);

  localparam int unsigned DW    = 2 * W;
  localparam int unsigned CW    = $clog2(DW + 1);
  localparam logic [CW-1:0] CAP = CW'(DW);
  localparam logic [CW-1:0] ONE = CW'(1);

  div_state_e     st;
  logic [DW:0]    dreg;     // divisor copy with one guard bit
  logic [DW-1:0]  acc;      // partial remainder
  logic [DW-1:0]  quo;
  logic [CW-1:0]  cnt;
  logic [W-1:0]   dmag;

  // Named internal events
  logic           norm_step;
  logic           norm_exit;
  logic [DW:0]    dsh;
  logic           borrow;
  logic [DW-1:0]  acc_sub;

  assign norm_step = (st == ST_NORM) && (dreg <= {1'b0, acc}) && (cnt < CAP);
  assign norm_exit = (st == ST_NORM) && !norm_step;
  assign dsh       = dreg >> 1;
  assign borrow    = dsh > {1'b0, acc};
  assign acc_sub   = acc - dsh[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      dreg <= '0;
      acc  <= '0;
      quo  <= '0;
      cnt  <= '0;
      dmag <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (load) begin
            dreg <= {{(W+1){1'b0}}, dvs_mag};
            acc  <= dvd_mag;
            quo  <= '0;
            cnt  <= '0;
            dmag <= dvs_mag;
            st   <= ST_NORM;
          end
        end
        ST_NORM: begin
          if (norm_step) begin
            dreg <= dreg << 1;
            cnt  <= cnt + ONE;
          end else begin
            st <= (cnt == '0) ? ST_FIN : ST_DIV;
          end
        end
        ST_DIV: begin
          dreg <= dsh;
          quo  <= {quo[DW-2:0], ~borrow};
          if (!borrow) acc <= acc_sub;
          cnt  <= cnt - ONE;
          if (cnt == ONE) st <= ST_FIN;
        end
        ST_FIN: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (st != ST_IDLE);
  assign fin     = (st == ST_FIN);
  assign quo_raw = quo;
  assign rem_raw = acc[W-1:0];

  // R3: the restoring phase never runs with an exhausted step count
  a_r3_div_steps_left: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DIV) |-> (cnt != '0));

  // R3: the normalise count never exceeds the double width
  a_r3_norm_capped: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CAP);

  // R5: the final partial remainder is below the divisor magnitude
  a_r5_rem_below_dvs: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (acc < {{W{1'b0}}, dmag}));

  // R9: zero normalise steps skip the restoring phase
  a_r9_skip_to_fin: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_exit && (cnt == '0)) |=> fin);

endmodule

// File: rtl/seqdiv_post.sv
// Result stage: reapplies signs and detects a quotient that does not fit.
module seqdiv_post #(
  parameter int unsigned W = 64
) (
  input  logic           signed_mode,
  input  logic           neg_quo,
  input  logic           neg_rem,
  input  logic [2*W-1:0] quo_raw,
  input  logic [W-1:0]   rem_raw,
  output logic [W-1:0]   quo_out,
  output logic [W-1:0]   rem_out,
  output logic           quo_ovf
);

  function automatic logic [2*W-1:0] negate_wide(input logic [2*W-1:0] v, input logic neg);
    negate_wide = neg ? (~v + {{(2*W-1){1'b0}}, 1'b1}) : v;
  endfunction

  function automatic logic [W-1:0] negate_narrow(input logic [W-1:0] v, input logic neg);
    negate_narrow = neg ? (~v + {{(W-1){1'b0}}, 1'b1}) : v;
  endfunction

  // Signed fit: bits W-1 upward must all equal the sign
  function automatic logic fits_signed(input logic [2*W-1:0] v);
    logic [W:0] upper;
    upper = v[2*W-1:W-1];
    fits_signed = (&upper) || !(|upper);
  endfunction

  logic [2*W-1:0] quo_signed;

  assign quo_signed = negate_wide(quo_raw, signed_mode & neg_quo);
  assign quo_out    = quo_signed[W-1:0];
  assign rem_out    = negate_narrow(rem_raw, signed_mode & neg_rem);
  assign quo_ovf    = signed_mode ? !fits_signed(quo_signed) : (|quo_raw[2*W-1:W]);

endmodule

// File: rtl/seqdiv_top.sv
module seqdiv_top
  import seqdiv_pkg::*;
#(
  parameter int unsigned W = DIV_W_DEFAULT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         signed_mode,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] dvsr,
  output logic         busy,
  output logic         done,
  output logic         div_err,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);

  logic [2*W-1:0] dvd_mag;
  logic [W-1:0]   dvs_mag;
  logic           neg_quo, neg_rem, dvs_zero, min_by_m1;
  logic           early_err, accept, load;
  logic           core_busy, core_fin;
  logic [2*W-1:0] quo_raw;
  logic [W-1:0]   rem_raw;
  logic [W-1:0]   quo_fix, rem_fix;
  logic           quo_ovf;

  logic           mode_q, nq_q, nr_q;
  logic           done_q, err_q;
  logic [W-1:0]   quot_q, rem_q;

  seqdiv_prep #(.W(W)) u_prep (
    .signed_mode (signed_mode),
    .dvd_hi      (dvd_hi),
    .dvd_lo      (dvd_lo),
    .dvsr        (dvsr),
    .dvd_mag     (dvd_mag),
    .dvs_mag     (dvs_mag),
    .neg_quo     (neg_quo),
    .neg_rem     (neg_rem),
    .dvs_zero    (dvs_zero),
    .min_by_m1   (min_by_m1)
  );

  assign early_err = dvs_zero | min_by_m1;
  assign accept    = start & ~core_busy;
  assign load      = accept & ~early_err;

  seqdiv_core #(.W(W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .dvd_mag (dvd_mag),
    .dvs_mag (dvs_mag),
    .busy    (core_busy),
    .fin     (core_fin),
    .quo_raw (quo_raw),
    .rem_raw (rem_raw)
  );

  seqdiv_post #(.W(W)) u_post (
    .signed_mode (mode_q),
    .neg_quo     (nq_q),
    .neg_rem     (nr_q),
    .quo_raw     (quo_raw),
    .rem_raw     (rem_raw),
    .quo_out     (quo_fix),
    .rem_out     (rem_fix),
    .quo_ovf     (quo_ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      nq_q   <= 1'b0;
      nr_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      quot_q <= '0;
      rem_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (load) begin
        mode_q <= signed_mode;
        nq_q   <= neg_quo;
        nr_q   <= neg_rem;
      end
      if (accept && early_err) begin
        done_q <= 1'b1;
        err_q  <= 1'b1;
      end else if (core_fin) begin
        done_q <= 1'b1;
        err_q  <= quo_ovf;
        if (!quo_ovf) begin
          quot_q <= quo_fix;
          rem_q  <= rem_fix;
        end
      end
    end
  end

  assign busy    = core_busy;
  assign done    = done_q;
  assign div_err = err_q;
  assign quot    = quot_q;
  assign rem     = rem_q;

  // R2: zero divisor reports at once
  a_r2_zero_dvs: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && dvsr == '0) |=> (done && div_err));

  // R6: most negative by minus one reports at once
  a_r6_min_by_m1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && min_by_m1) |=> (done && div_err));

  // R8: an error leaves the visible result untouched
  a_r8_hold_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |-> ($stable(quot) && $stable(rem)));

  // R10: completion is never flagged while busy
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10: busy only ends with a completion
  a_r10_busy_to_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  // R10: error flag only accompanies done
  a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |-> done);

endmodule

// File: tb/test_seqdiv_top.sv
module test_seqdiv_top;

  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        signed_mode = 1'b0;
  logic [63:0] dvd_hi = '0, dvd_lo = '0, dvsr = '0;
  logic        busy, done, div_err;
  logic [63:0] quot, rem;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] last_q = '0, last_r = '0;

  always #(CLK_NS/2) clk = ~clk;

  seqdiv_top i_seqdiv_top (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
    .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvsr(dvsr),
    .busy(busy), .done(done), .div_err(div_err), .quot(quot), .rem(rem)
  );

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: wide integer arithmetic plus a doubling loop for latency
  task automatic run_op(input string req, input bit sm, input logic [63:0] hi, input logic [63:0] lo,
                        input logic [63:0] d, input bit poke);
    logic [127:0] a, am, q, r, qs;
    logic [63:0]  dm, rs;
    logic [128:0] t;
    bit a_neg, d_neg, err, early;
    int n, lat;
    a     = {hi, lo};
    a_neg = sm && hi[63];
    d_neg = sm && d[63];
    am    = a_neg ? -a : a;
    dm    = d_neg ? -d : d;
    early = (d == 64'd0) || (sm && d == '1 && hi == 64'h8000_0000_0000_0000 && lo == 64'd0);
    err   = early;
    qs    = '0;
    rs    = '0;
    n     = 0;
    if (!early) begin
      q = am / {64'd0, dm};
      r = am % {64'd0, dm};
      if (sm) begin
        qs  = (a_neg ^ d_neg) ? -q : q;
        rs  = a_neg ? -r[63:0] : r[63:0];
        err = !((qs[127:63] == '0) || (qs[127:63] == '1));
      end else begin
        qs  = q;
        rs  = r[63:0];
        err = (q[127:64] != 64'd0);
      end
      t = {65'd0, dm};
      while (n < 128 && t <= {1'b0, am}) begin
        t = t << 1;
        n++;
      end
    end
    lat = early ? 0 : 2 * n + 2;

    @(negedge clk);
    signed_mode = sm; dvd_hi = hi; dvd_lo = lo; dvsr = d; start = 1'b1;
    @(posedge clk);
    for (int e = 0; e <= lat; e++) begin
      if (e > 0) @(posedge clk);
      @(negedge clk);
      if (e == 0) start = 1'b0;
      if (poke && e == 2) begin
        // R10: a start while busy with an erroring operand set must be ignored
        start = 1'b1; dvsr = 64'd0; signed_mode = ~sm;
      end
      if (poke && e == 3) begin
        start = 1'b0; dvsr = d; signed_mode = sm;
      end
      chk("R10", "busy", busy, (e < lat));
      chk(req, "done timing", done, (e == lat));
      if (e == lat) begin
        chk(req, "div_err", div_err, err);
        if (!err) begin
          last_q = qs[63:0];
          last_r = rs;
        end
        chk(err ? "R8" : req, "quot", quot, last_q);
        chk(err ? "R8" : req, "rem", rem, last_r);
      end
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs cleared during reset
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "div_err", div_err, 0);
    chk("R1", "quot", quot, 0);
    chk("R1", "rem", rem, 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "busy after release", busy, 0);
    chk("R1", "done after release", done, 0);

    run_op("R3", 1'b0, 64'd0, 64'd100, 64'd7, 1'b0);
    run_op("R9", 1'b0, 64'd0, 64'd5, 64'd9, 1'b0);
    run_op("R2", 1'b0, 64'h1234, 64'h5678, 64'd0, 1'b0);
    run_op("R4", 1'b0, 64'd1, 64'd0, 64'd1, 1'b0);
    run_op("R3", 1'b0, 64'd3, 64'h1234_5678_9abc_def0, 64'hffff_ffff_0000_0001, 1'b0);
    run_op("R3", 1'b0, 64'hffff_ffff_ffff_fffe, 64'h0f0f_a5a5_3c3c_9696, 64'hffff_ffff_ffff_ffff, 1'b0);
    run_op("R10", 1'b0, 64'd0, 64'hdead_beef_cafe_f00d, 64'd3, 1'b1);
    run_op("R5", 1'b1, '1, -64'd100, 64'd7, 1'b0);
    run_op("R5", 1'b1, 64'd0, 64'd100, -64'd7, 1'b0);
    run_op("R5", 1'b1, '1, -64'd100, -64'd7, 1'b0);
    run_op("R2", 1'b1, '1, -64'd3, 64'd0, 1'b0);
    run_op("R6", 1'b1, 64'h8000_0000_0000_0000, 64'd0, '1, 1'b0);
    run_op("R7", 1'b1, 64'd0, 64'h8000_0000_0000_0000, 64'd1, 1'b0);
    run_op("R5", 1'b1, '1, 64'h8000_0000_0000_0000, 64'd1, 1'b0);
    run_op("R9", 1'b1, 64'd0, 64'd5, 64'h8000_0000_0000_0000, 1'b0);
    run_op("R7", 1'b1, 64'h0000_0000_0000_0004, 64'd0, 64'd3, 1'b0);
    run_op("R9", 1'b1, '1, -64'd2, 64'd9, 1'b0);
    finish_run();
  end

endmodule